// File: doc/BRIEF.md
# Two-Wire Serial Shift Unit

This block is the bit-level engine behind a two-wire serial slave. A sequencer or CPU drives it through four small registers. An 8-bit data register samples SDA on each rising SCL edge. A 4-bit edge counter advances on both SCL edges, so it wraps after one byte, or after fewer bits when it is preloaded. Line detectors flag START and STOP conditions. Clock stretching follows the pending START and overflow flags.

Address matching, buffering and protocol sequencing belong to the controlling agent. That agent reads the status register, reloads the counter and clears flags. It preloads the data register to drive SDA. No data stream crosses this block's edge, so every pin is a plain control or status pin and there is no valid/ready handshake.

All line events are taken from the SCL and SDA inputs. The inputs are compared against their values in the previous clock. A change seen at one clock edge takes effect in the registers at that same edge.

Top module: `twi_shift_unit`

## Requirements
- R1: After reset the control, status and data registers read 0x00, and the block does not drive SCL or SDA low. It also does not raise `irq_o`.
- R2: On each SCL rising edge the data register (address 2) shifts left by one and takes the sampled SDA level into bit 0. Falling edges do not shift it.
- R3: The edge counter (status bits 3:0) increments on every SCL rising and falling edge. It wraps from 15 to 0 and sets the overflow flag (status bit 6) on the wrap. A preload of 0 gives overflow after 8 bits, and a preload of 0xE gives overflow after 1 bit.
- R4: A START (SDA falls while SCL stays high) sets the START flag (status bit 7). `irq_o` is high while that flag is set and control bit 0 is 1.
- R5: A STOP (SDA rises while SCL stays high) sets the STOP flag (status bit 5). It never stretches SCL.
- R6: Control bits 3:2 select the wire mode, with the following effect on `scl_low_o`:
  - 2'b10: `scl_low_o` is high while the START flag is set.
  - 2'b11: `scl_low_o` is also high while the overflow flag is set.
  - 2'b0x: SCL is never held low.
- R7: Writing the status register (address 1) clears each flag in bits 7:4 that has a 1 written to it. A 0 written to a flag leaves it unchanged. The same write loads bits 3:0 into the counter. A flag that is set in the same cycle as its clear stays set.
- R8: When control bit 4 is 1, `sda_low_o` equals the inverse of data register bit 7. When control bit 4 is 0, SDA is released.
- R9: The collision flag (status bit 4) is set at an SCL rising edge when control bit 4 is 1 and data bit 7 differs from the sampled SDA level.
- R10: `irq_o` is also high while the overflow flag is set and control bit 1 is 1.
- R11: A register write takes precedence over the shift or the count in the same cycle. The control register (address 0) reads back all 8 bits written to it, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_low_o | output | 1 | Pull SCL low (clock stretch) |
| sda_low_o | output | 1 | Pull SDA low |
| irq_o | output | 1 | Interrupt request |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |

## Verification
The unit is driven with several byte patterns:
- A full byte of alternating bits after a START shows that sampling happens on rising edges only and that MSB-first order holds.
- A one-bit acknowledge phase with a 0xE preload separates the edge counter's double-edge counting from a per-bit count.
- A phase in which the unit drives low while the line reads high exercises the collision flag.
- A STOP sequence tells a STOP apart from a START.

Wire-mode switches with flags pending show which flag each mode stretches the clock for. A behavioural model compares every output on every clock.

// File: rtl/twi_shift_pkg.sv
package twi_shift_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  typedef struct packed {
    logic [2:0] spare;
    logic       sda_oe;
    logic [1:0] wmode;
    logic       ovf_ie;
    logic       start_ie;
  } ctrl_t;
endpackage

// File: rtl/twi_line_watch.sv
module twi_line_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/twi_edge_counter.sv
module twi_edge_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  assign wrap = tick & ~load & (cnt == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (tick) cnt <= cnt + 1'b1;
  end

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cnt == TOP) |=> (cnt == '0));
  assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/twi_shift_reg.sv
module twi_shift_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         bit_in,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= {q[W-2:0], bit_in};
  end

  assert_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |=> (q == {$past(q[W-2:0]), $past(bit_in)}));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift && !load) |=> $stable(q));
endmodule

// File: rtl/twi_shift_unit.sv
module twi_shift_unit #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_low_o,
  output logic              sda_low_o,
  output logic              irq_o,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  import twi_shift_pkg::*;

  localparam int CNT_W = $clog2(2 * DATA_W);
  localparam int FLG   = DATA_W - 1;

  ctrl_t ctrl;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic [CNT_W-1:0]  cnt;
  logic              wrap;
  logic [DATA_W-1:0] data;
  logic start_f, ovf_f, stop_f, coll_f;
  logic ctrl_wr, stat_wr, data_wr, coll_det;

  assign ctrl_wr = reg_wr && reg_addr == ADDR_CTRL;
  assign stat_wr = reg_wr && reg_addr == ADDR_STAT;
  assign data_wr = reg_wr && reg_addr == ADDR_DATA;

  twi_line_watch u_watch (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twi_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(stat_wr), .load_val(reg_wdata[CNT_W-1:0]),
    .tick(scl_rise | scl_fall), .cnt(cnt), .wrap(wrap)
  );

  twi_shift_reg #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(data_wr), .load_val(reg_wdata),
    .shift(scl_rise), .bit_in(sda_i), .q(data)
  );

  assign coll_det = scl_rise & ctrl.sda_oe & (data[DATA_W-1] != sda_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl    <= '0;
      start_f <= 1'b0;
      ovf_f   <= 1'b0;
      stop_f  <= 1'b0;
      coll_f  <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl <= ctrl_t'(reg_wdata[7:0]);
      if (start_det)                      start_f <= 1'b1;
      else if (stat_wr && reg_wdata[FLG]) start_f <= 1'b0;
      if (wrap)                             ovf_f <= 1'b1;
      else if (stat_wr && reg_wdata[FLG-1]) ovf_f <= 1'b0;
      if (stop_det)                          stop_f <= 1'b1;
      else if (stat_wr && reg_wdata[FLG-2])  stop_f <= 1'b0;
      if (coll_det)                          coll_f <= 1'b1;
      else if (stat_wr && reg_wdata[FLG-3])  coll_f <= 1'b0;
    end
  end

  assign scl_low_o = ctrl.wmode[1] & (start_f | (ctrl.wmode[0] & ovf_f));
  assign sda_low_o = ctrl.sda_oe & ~data[DATA_W-1];
  assign irq_o     = (ctrl.start_ie & start_f) | (ctrl.ovf_ie & ovf_f);

  always_comb begin
    unique case (reg_addr)
      ADDR_CTRL: reg_rdata = DATA_W'(ctrl);
      ADDR_STAT: reg_rdata = DATA_W'({start_f, ovf_f, stop_f, coll_f, cnt});
      ADDR_DATA: reg_rdata = data;
      default:   reg_rdata = '0;
    endcase
  end

  assert_start_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && ctrl.wmode[1] && !ctrl_wr) |=> scl_low_o);
  assert_start_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && ctrl.start_ie && !ctrl_wr) |=> irq_o);
  assert_clear_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && reg_wdata[FLG] && !start_det) |=> !start_f);
  assert_keep_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !reg_wdata[FLG-2] && stop_f) |=> stop_f);
  assert_ack_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !reg_wdata[DATA_W-1] && ctrl.sda_oe && !ctrl_wr) |=> sda_low_o);
  assert_ovf_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && ctrl.ovf_ie && !ctrl_wr) |=> irq_o);
endmodule

// File: tb/test_twi_shift_unit.sv
module test_twi_shift_unit;
  localparam int T = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_i = 1'b1, sda_i = 1'b1;
  logic scl_low_o, sda_low_o, irq_o;
  logic [1:0] reg_addr = 2'd0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;

  int total = 0, bad = 0;
  bit done = 0;

  always #(T/2) clk = ~clk;

  twi_shift_unit i_twi_shift_unit (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .irq_o(irq_o),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  // behavioural reference
  int m_ctrl, m_data, m_cnt;
  bit m_st, m_ov, m_sp, m_co, p_scl, p_sda;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_data = 0; m_cnt = 0;
      m_st = 0; m_ov = 0; m_sp = 0; m_co = 0; p_scl = 1; p_sda = 1;
    end else begin
      bit rise, fall, wr_s;
      rise = scl_i && !p_scl;
      fall = !scl_i && p_scl;
      wr_s = reg_wr && reg_addr == 1;
      if (wr_s) begin
        if (reg_wdata[7]) m_st = 0;
        if (reg_wdata[6]) m_ov = 0;
        if (reg_wdata[5]) m_sp = 0;
        if (reg_wdata[4]) m_co = 0;
      end
      if (scl_i && p_scl && p_sda && !sda_i) m_st = 1;
      if (scl_i && p_scl && !p_sda && sda_i) m_sp = 1;
      if (rise && m_ctrl[4] && (m_data[7] != sda_i)) m_co = 1;
      if (wr_s) m_cnt = reg_wdata[3:0];
      else if (rise || fall) begin
        if (m_cnt == 15) begin m_cnt = 0; m_ov = 1; end
        else m_cnt = m_cnt + 1;
      end
      if (reg_wr && reg_addr == 2) m_data = reg_wdata;
      else if (rise) m_data = ((m_data << 1) | int'(sda_i)) & 255;
      if (reg_wr && reg_addr == 0) m_ctrl = reg_wdata;
      p_scl = scl_i; p_sda = sda_i;
    end
  end

  function automatic int m_read(int a);
    case (a)
      0: return m_ctrl;
      1: return (int'(m_st) << 7) | (int'(m_ov) << 6) | (int'(m_sp) << 5) | (int'(m_co) << 4) | m_cnt;
      2: return m_data;
      default: return 0;
    endcase
  endfunction

  task automatic chk(int act, int exp, string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(posedge clk) begin
    #(T/4);
    if (rst_n) begin
      bit exp_scl, exp_irq;
      exp_scl = m_ctrl[3] && (m_st || (m_ctrl[2] && m_ov));
      exp_irq = (m_ctrl[0] && m_st) || (m_ctrl[1] && m_ov);
      chk(int'(scl_low_o), int'(exp_scl), "R6 scl_low");
      chk(int'(sda_low_o), int'(m_ctrl[4] && !m_data[7]), "R8 sda_low");
      chk(int'(irq_o), int'(exp_irq), "R4/R10 irq");
      chk(int'(reg_rdata), m_read(int'(reg_addr)), "R11 rdata");
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); reg_addr = 2'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic pins(bit c, bit d);
    @(negedge clk); scl_i = c; sda_i = d;
    @(negedge clk);
  endtask

  task automatic rd(int a, int exp, string tag);
    @(negedge clk); reg_addr = 2'(a);
    @(posedge clk); #(T/4);
    chk(int'(reg_rdata), exp, tag);
  endtask

  task automatic pin_chk(logic v, int exp, string tag);
    @(posedge clk); #(T/4);
    chk(int'(v), exp, tag);
  endtask

  initial begin
    #(T * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit [7:0] pat;
    pat = 8'hA5;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    rd(0, 8'h00, "R1 ctrl");
    rd(1, 8'h00, "R1 status");
    rd(2, 8'h00, "R1 data");
    rd(3, 8'h00, "R11 addr3");
    pin_chk(scl_low_o, 0, "R1 scl");
    pin_chk(irq_o, 0, "R1 irq");
    wr(0, 8'h09);
    rd(0, 8'h09, "R11 ctrl readback");
    pins(1, 0);                     // START
    rd(1, 8'h80, "R4 start flag");
    pin_chk(irq_o, 1, "R4 irq");
    pin_chk(scl_low_o, 1, "R6 start stretch");
    pins(0, 0);
    rd(1, 8'h81, "R3 fall counts");
    wr(1, 8'h80);
    rd(1, 8'h00, "R7 clear and load");
    pin_chk(scl_low_o, 0, "R6 released");
    for (int i = 7; i >= 0; i--) begin
      pins(0, pat[i]);
      pins(1, pat[i]);
      pins(0, pat[i]);
    end
    rd(2, 8'hA5, "R2 byte shifted");
    rd(1, 8'h40, "R3 overflow after 8 bits");
    pin_chk(scl_low_o, 0, "R6 plain mode no ovf stretch");
    wr(0, 8'h0D);
    pin_chk(scl_low_o, 1, "R6 hold mode ovf stretch");
    pin_chk(irq_o, 0, "R10 ovf irq disabled");
    wr(0, 8'h0F);
    pin_chk(irq_o, 1, "R10 ovf irq");
    wr(2, 8'h00);
    wr(0, 8'h1C);
    pin_chk(sda_low_o, 1, "R8 ack drive");
    wr(1, 8'h4E);
    rd(1, 8'h0E, "R3 preload E");
    pins(0, 0);
    pins(1, 0);
    pins(0, 0);
    rd(1, 8'h40, "R3 overflow after 1 bit");
    wr(1, 8'h4E);
    pins(0, 1);
    pins(1, 1);
    pins(0, 1);
    rd(1, 8'h50, "R9 collision");
    rd(2, 8'h01, "R2 shift in one");
    wr(0, 8'h08);
    pin_chk(sda_low_o, 0, "R8 released");
    wr(1, 8'hF0);
    rd(1, 8'h00, "R7 clear all");
    pins(0, 0);
    pins(1, 0);
    pins(1, 1);                     // STOP
    rd(1, 8'h21, "R5 stop flag");
    pin_chk(scl_low_o, 0, "R5 no stretch");
    rd(2, 8'h02, "R2 data after stop");
    wr(1, 8'h00);
    rd(1, 8'h20, "R7 zero keeps flag");
    wr(1, 8'h25);
    rd(1, 8'h05, "R7 clear stop");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule